// File: doc/BRIEF.md
# Shared Priority Dispatch Register

This block is a shared hardware scheduling point for a small symmetric multiprocessor. Any processor port or I/O-device port may post a task number, which marks that task as wanting to run. The set of posted tasks is held as one bit per task number. Posting a task that is already marked changes nothing, so requests are merged rather than counted.

Each processor port may also issue a read. One clock later it receives the most urgent task still marked, and that task is cleared in the same clock edge. A read therefore hands each request to exactly one processor. Task 0 is the most urgent, and a smaller number always wins. When nothing is marked, the read still answers, with an empty flag set and a zero task field.

When several processors read in the same cycle, they are served one after another by port index. A write and a read of the same task in the same cycle leave the task marked.

Top module: `shared_dispatch_reg`

## Requirements
- R1: A synchronous active-low reset (`rst_n` low at a rising edge) clears every pending task and drives all `rd_valid` bits low.
- R2: A write on any processor write port or I/O write port (`*_wr_valid` high, with the task number on the matching `*_wr_task` field) marks that task pending from the next edge onward.
- R3: `rd_valid[i]` is high in exactly the cycle after `rd_req[i]` was sampled high. The pending set is updated at that same edge.
- R4: A non-empty response carries the lowest-numbered pending task, with `rd_empty[i]`=0 and the task in `rd_task[i*TASK_W +: TASK_W]`.
- R5: A task returned by a read is no longer pending afterwards, so a later read does not return it again unless it is written again.
- R6: Writing a task that is already pending, or writing it from several ports at once, leaves a single pending entry, which a single read consumes.
- R7: A read with nothing pending gives `rd_valid`=1, `rd_empty`=1 and a task field of all zeros, and it leaves the pending set unchanged.
- R8: Reads issued together are served in ascending port-index order. Each port gets the next distinct lowest pending task, and a port gets an empty response once the pending tasks run out.
- R9: If a task is returned by a read and written in the same cycle, it stays pending after that read.
- R10: Every task number from 0 through `NUM_TASKS-1` can be posted and dispatched, including the highest one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_wr_valid | input | NUM_CPU | Per processor port: post a task this cycle |
| cpu_wr_task | input | NUM_CPU*TASK_W | Per processor port: task number to post |
| io_wr_valid | input | NUM_IO | Per I/O port: post a task this cycle |
| io_wr_task | input | NUM_IO*TASK_W | Per I/O port: task number to post |
| rd_req | input | NUM_CPU | Per processor port: dispatch read request |
| rd_valid | output | NUM_CPU | Per processor port: response present (one cycle after request) |
| rd_empty | output | NUM_CPU | Per processor port: response found nothing pending |
| rd_task | output | NUM_CPU*TASK_W | Per processor port: dispatched task number, zero when empty |

## Verification
The bench builds the block with its defaults: 64 task numbers, four processor ports and two I/O ports. With these values task 63 can be posted through the top of the vector. Four simultaneous readers can exhaust a set of three pending tasks, so the last port in the grant order receives an empty answer. Two I/O ports together with four processor write ports allow six writers to collide on one task number, which exercises request merging under the widest fan-in.

// File: rtl/dispatch_pkg.sv
// dispatch_pkg
// Shared helpers for the dispatch register.
// Assumes: task vectors are at most a few hundred bits wide.
package dispatch_pkg;

    // Width of a task number for a given task count (at least one bit).
    function automatic int task_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/dispatch_set_merge.sv
// dispatch_set_merge
// Turns every writer's (valid, task) pair into one mask of tasks to set.
// Because the writes are ORed together, duplicate writes merge into one bit.
// Assumes: task numbers at or above NUM_TASKS are dropped.
module dispatch_set_merge #(
    parameter int NUM_TASKS = 64,
    parameter int NUM_WR    = 6,
    parameter int TASK_W    = 6
) (
    input  logic [NUM_WR-1:0]        wr_valid,
    input  logic [NUM_WR*TASK_W-1:0] wr_task,
    output logic [NUM_TASKS-1:0]     set_mask
);

    // Purpose: decode each writer and OR all of them into the set mask.
    always_comb begin
        set_mask = '0;
        for (int w = 0; w < NUM_WR; w++) begin
            for (int t = 0; t < NUM_TASKS; t++) begin
                if (wr_valid[w] && (wr_task[w*TASK_W +: TASK_W] == TASK_W'(t)))
                    set_mask[t] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/dispatch_pick.sv
// dispatch_pick
// Finds the lowest set bit of a task vector (task 0 is the most urgent).
// Outputs the one-hot form, its index and whether any bit was set.
// Assumes: a purely combinational use inside the grant chain.
module dispatch_pick #(
    parameter int NUM_TASKS = 64,
    parameter int TASK_W    = 6
) (
    input  logic [NUM_TASKS-1:0] vec,
    output logic                 found,
    output logic [NUM_TASKS-1:0] onehot,
    output logic [TASK_W-1:0]    idx
);

    // Purpose: isolate the lowest set bit.
    always_comb begin
        found  = |vec;
        onehot = vec & (-vec);
    end

    // Purpose: encode the one-hot bit into a task number.
    always_comb begin
        idx = '0;
        for (int t = 0; t < NUM_TASKS; t++) begin
            if (onehot[t]) idx = idx | TASK_W'(t);
        end
    end

endmodule

// File: rtl/dispatch_grant_chain.sv
// dispatch_grant_chain
// Serves the read requests of one cycle in ascending port order.
// Each requesting port takes the lowest task left after all lower ports,
// so no two ports receive the same task.
// Assumes: pending is the registered set at the start of the cycle.
module dispatch_grant_chain #(
    parameter int NUM_TASKS = 64,
    parameter int NUM_CPU   = 4,
    parameter int TASK_W    = 6
) (
    input  logic [NUM_TASKS-1:0]      pending,
    input  logic [NUM_CPU-1:0]        rd_req,
    output logic [NUM_CPU-1:0]        got,
    output logic [NUM_CPU*TASK_W-1:0] got_task,
    output logic [NUM_TASKS-1:0]      remain
);

    logic [NUM_TASKS-1:0] avail [NUM_CPU+1];
    logic [NUM_TASKS-1:0] hot   [NUM_CPU];
    logic [NUM_CPU-1:0]   fnd;

    assign avail[0] = pending;

    for (genvar p = 0; p < NUM_CPU; p++) begin : g_stage
        dispatch_pick #(
            .NUM_TASKS (NUM_TASKS),
            .TASK_W    (TASK_W)
        ) u_pick (
            .vec    (avail[p]),
            .found  (fnd[p]),
            .onehot (hot[p]),
            .idx    (got_task[p*TASK_W +: TASK_W])
        );

        // Purpose: remove this port's grant before the next port looks.
        always_comb begin
            got[p]     = rd_req[p] && fnd[p];
            avail[p+1] = rd_req[p] ? (avail[p] & ~hot[p]) : avail[p];
        end
    end

    assign remain = avail[NUM_CPU];

endmodule

// File: rtl/shared_dispatch_reg.sv
// shared_dispatch_reg
// Holds one pending bit per task. Any writer may set a bit, and each processor
// read pops the lowest pending task, with the answer registered one clock
// later. A write in the same cycle overrides a pop of the same task.
// Assumes: synchronous active-low reset; writers never stall.
module shared_dispatch_reg #(
    parameter int NUM_TASKS = 64,
    parameter int NUM_CPU   = 4,
    parameter int NUM_IO    = 2,
    localparam int TASK_W   = dispatch_pkg::task_width(NUM_TASKS),
    localparam int NUM_WR   = NUM_CPU + NUM_IO
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_CPU-1:0]        cpu_wr_valid,
    input  logic [NUM_CPU*TASK_W-1:0] cpu_wr_task,
    input  logic [NUM_IO-1:0]         io_wr_valid,
    input  logic [NUM_IO*TASK_W-1:0]  io_wr_task,
    input  logic [NUM_CPU-1:0]        rd_req,
    output logic [NUM_CPU-1:0]        rd_valid,
    output logic [NUM_CPU-1:0]        rd_empty,
    output logic [NUM_CPU*TASK_W-1:0] rd_task
);

    logic [NUM_TASKS-1:0]      pending_q;
    logic [NUM_TASKS-1:0]      set_mask;
    logic [NUM_TASKS-1:0]      remain;
    logic [NUM_CPU-1:0]        got;
    logic [NUM_CPU*TASK_W-1:0] got_task;

    dispatch_set_merge #(
        .NUM_TASKS (NUM_TASKS),
        .NUM_WR    (NUM_WR),
        .TASK_W    (TASK_W)
    ) u_merge (
        .wr_valid ({io_wr_valid, cpu_wr_valid}),
        .wr_task  ({io_wr_task, cpu_wr_task}),
        .set_mask (set_mask)
    );

    dispatch_grant_chain #(
        .NUM_TASKS (NUM_TASKS),
        .NUM_CPU   (NUM_CPU),
        .TASK_W    (TASK_W)
    ) u_chain (
        .pending  (pending_q),
        .rd_req   (rd_req),
        .got      (got),
        .got_task (got_task),
        .remain   (remain)
    );

    // Purpose: pending set update; writes are applied after pops, so they win.
    always_ff @(posedge clk) begin
        if (!rst_n) pending_q <= '0;
        else        pending_q <= remain | set_mask;
    end

    // Purpose: register each port's answer one clock after its request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= '0;
            rd_empty <= '0;
            rd_task  <= '0;
        end else begin
            rd_valid <= rd_req;
            for (int p = 0; p < NUM_CPU; p++) begin
                rd_empty[p]                <= rd_req[p] && !got[p];
                rd_task[p*TASK_W +: TASK_W] <= got[p] ? got_task[p*TASK_W +: TASK_W] : '0;
            end
        end
    end

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (pending_q == '0) && (rd_valid == '0));

    // R7
    empty_keeps_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_q == '0 && set_mask == '0) |=> pending_q == '0);

    for (genvar i = 0; i < NUM_CPU; i++) begin : g_port_chk
        // R3
        resp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> rd_valid[i] == $past(rd_req[i]));

        // R7
        empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_valid[i] && rd_empty[i]) |-> rd_task[i*TASK_W +: TASK_W] == '0);

        // R4
        was_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_req[i] && got[i]) |=>
                ((($past(pending_q) >> rd_task[i*TASK_W +: TASK_W]) & 1) != 0));

        for (genvar j = i + 1; j < NUM_CPU; j++) begin : g_pair
            // R8
            distinct_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (rd_valid[i] && !rd_empty[i] && rd_valid[j] && !rd_empty[j]) |->
                    rd_task[i*TASK_W +: TASK_W] != rd_task[j*TASK_W +: TASK_W]);
        end
    end

endmodule

// File: tb/shared_dispatch_reg_test.sv
// shared_dispatch_reg_test
// Behavioural reference model (an integer-indexed bit array) stepped on every
// clock and compared with every read port on every cycle.
module shared_dispatch_reg_test;

    localparam int NT = 64;
    localparam int NC = 4;
    localparam int NI = 2;
    localparam int TW = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NC-1:0]    cpu_wr_valid = '0;
    logic [NC*TW-1:0] cpu_wr_task = '0;
    logic [NI-1:0]    io_wr_valid = '0;
    logic [NI*TW-1:0] io_wr_task = '0;
    logic [NC-1:0]    rd_req = '0;
    logic [NC-1:0]    rd_valid;
    logic [NC-1:0]    rd_empty;
    logic [NC*TW-1:0] rd_task;

    int vectors = 0;
    int errors = 0;
    bit model [NT];
    bit exp_v [NC];
    bit exp_e [NC];
    int exp_t [NC];

    always #5 clk = ~clk;

    shared_dispatch_reg uut (
        .clk(clk), .rst_n(rst_n),
        .cpu_wr_valid(cpu_wr_valid), .cpu_wr_task(cpu_wr_task),
        .io_wr_valid(io_wr_valid), .io_wr_task(io_wr_task),
        .rd_req(rd_req), .rd_valid(rd_valid), .rd_empty(rd_empty), .rd_task(rd_task)
    );

    // Step the model over one clock, then compare all ports after the edge.
    task automatic step(input string tag);
        for (int p = 0; p < NC; p++) begin
            exp_v[p] = 1'b0; exp_e[p] = 1'b0; exp_t[p] = 0;
        end
        if (!rst_n) begin
            for (int t = 0; t < NT; t++) model[t] = 1'b0;
        end else begin
            for (int p = 0; p < NC; p++) begin
                if (rd_req[p]) begin
                    int pick = -1;
                    exp_v[p] = 1'b1;
                    for (int t = NT - 1; t >= 0; t--) if (model[t]) pick = t;
                    if (pick < 0) exp_e[p] = 1'b1;
                    else begin exp_t[p] = pick; model[pick] = 1'b0; end
                end
            end
            for (int p = 0; p < NC; p++)
                if (cpu_wr_valid[p]) model[int'(cpu_wr_task[p*TW +: TW])] = 1'b1;
            for (int p = 0; p < NI; p++)
                if (io_wr_valid[p]) model[int'(io_wr_task[p*TW +: TW])] = 1'b1;
        end
        @(posedge clk);
        #1;
        for (int p = 0; p < NC; p++) begin
            vectors++;
            if (rd_valid[p] !== exp_v[p] ||
                (exp_v[p] && (rd_empty[p] !== exp_e[p] ||
                              int'(rd_task[p*TW +: TW]) != exp_t[p]))) begin
                errors++;
                $display("FAIL %s port %0d: got v=%0b e=%0b t=%0d, expected v=%0b e=%0b t=%0d",
                         tag, p, rd_valid[p], rd_empty[p], rd_task[p*TW +: TW],
                         exp_v[p], exp_e[p], exp_t[p]);
            end
        end
        @(negedge clk);
        cpu_wr_valid = '0; io_wr_valid = '0; rd_req = '0;
    endtask

    task automatic cw(input int p, input int t);
        cpu_wr_valid[p] = 1'b1; cpu_wr_task[p*TW +: TW] = TW'(t);
    endtask

    task automatic iw(input int p, input int t);
        io_wr_valid[p] = 1'b1; io_wr_task[p*TW +: TW] = TW'(t);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1: reset holds outputs low even with a request present
        rd_req = '1; cw(0, 9);
        step("R1 reset");
        step("R1 reset");
        rst_n = 1'b1;
        rd_req[0] = 1'b1;
        step("R1 empty after reset");
        step("R3 response cycle");
        // R2: writes from an I/O port and a processor port
        iw(1, 10); cw(2, 5);
        step("R2 post");
        rd_req[0] = 1'b1;
        step("R2 R4 lowest");
        rd_req[1] = 1'b1;
        step("R5 consumed");
        rd_req[2] = 1'b1;
        step("R7 empty read");
        step("R3 no request");
        // R6: merging writes
        cw(0, 7); cw(3, 7); iw(0, 7);
        step("R6 post");
        cw(1, 7);
        step("R6 repost");
        rd_req[1] = 1'b1;
        step("R6 first read");
        rd_req[1] = 1'b1;
        step("R6 second read");
        // R8 and R10: four readers, three tasks including 63
        cw(0, 63); iw(0, 0); iw(1, 1);
        step("R10 post");
        rd_req = '1;
        step("R8 R10 concurrent");
        // R9: write and pop of the same task in one cycle
        cw(1, 20);
        step("R9 post");
        rd_req[3] = 1'b1; iw(0, 20);
        step("R9 read+write");
        rd_req[0] = 1'b1;
        step("R9 survives");
        rd_req[0] = 1'b1;
        step("R9 drained");
        // R4 R8: random traffic against the model
        for (int k = 0; k < 400; k++) begin
            for (int p = 0; p < NC; p++) begin
                if ($urandom_range(0, 3) == 0) cw(p, int'($urandom_range(0, NT - 1)));
                rd_req[p] = ($urandom_range(0, 2) == 0);
            end
            for (int p = 0; p < NI; p++)
                if ($urandom_range(0, 3) == 0) iw(p, int'($urandom_range(0, NT - 1)));
            step("R4 R8 random");
        end
        // R1: reset in mid-run clears the set
        cw(0, 3);
        step("R1 pre");
        rst_n = 1'b0;
        step("R1 mid reset");
        rst_n = 1'b1;
        rd_req[0] = 1'b1;
        step("R1 cleared");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule